// File: doc/BRIEF.md
# Converter Serial Result Readout

This block is the serial output stage of a 16-bit sampling converter whose serial clock is supplied by the host. The host selects the device with an active-low chip select and an active-low read enable, starts conversions with a one-cycle start pulse, and toggles the serial clock to move a result out on a single data line. The most significant bit comes first. The analog conversion is replaced by a timed busy window. When that window ends, the block captures a supplied result word.

A static mode input selects one of two ways of reading. In read-after-convert mode the host reads the latest result between conversions. In this mode the serial input is shifted in behind the block's own word, so the word of a second device wired to that input follows in the same burst. In read-during-conversion mode the host reads the last completed result while the next conversion runs. The serial input is ignored, and a one-cycle error flag marks a read that was left unfinished when the conversion ended.

The serial clock and serial input are brought into the system clock domain through a synchronizer. The output shifts on the detected falling edge of the serial clock, so each bit is steady around the following rising edge.

Top module: `adc_serial_readout`

## Requirements
- R1: An accepted start pulse raises `busy` on the next cycle, and `busy` stays high for exactly CONV_CYCLES cycles. A start pulse that arrives while `busy` is high is ignored.
- R2: The value on `result_in` in the last busy cycle becomes the latest result. A selection that begins after `busy` falls reads this value.
- R3: `sdout` is 0 in every cycle that follows a cycle in which `cs_n` or `rd_n` was high, including after reset.
- R4: After selection, bit 15 of the word is on `sdout` before the first rising serial clock edge. Each falling serial clock edge advances one bit, so bit 16-k is on `sdout` at rising edge k, for k from 1 to 16.
- R5: In read-during-conversion mode (`read_during_conv`=1), a selection made while a conversion runs returns the result of the previous conversion, not the one in progress.
- R6: In read-during-conversion mode, `rd_error` is high for exactly one cycle, the first cycle with `busy` low, if a read began during that conversion and fewer than 16 falling serial clock edges were counted when it ended. `rd_error` stays 0 after a complete read and always stays 0 in read-after-convert mode.
- R7: In read-during-conversion mode, `sdin` has no effect. At rising edges 17 and later, `sdout` is 0.
- R8: In read-after-convert mode (`read_during_conv`=0), the value of `sdin` at rising edge j is on `sdout` at rising edge j+16. This makes a second 16-bit word follow the block's own word, MSB first.
- R9: A read that starts between conversions may continue after a new start pulse. The word being shifted is not changed by the new conversion.
- R10: Deselecting with `cs_n` or `rd_n` high clears the bit count. The next selection starts again from bit 15 of the latest result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| rd_n | input | 1 | Read enable, active low, synchronous to clk |
| read_during_conv | input | 1 | Mode strap: 1 = read during conversion, 0 = read after conversion with chaining |
| cnv_start | input | 1 | One-cycle conversion start pulse |
| result_in | input | DW | Result word captured when the conversion ends |
| sclk | input | 1 | Host serial clock, asynchronous, idles low |
| sdin | input | 1 | Chain serial input, asynchronous |
| busy | output | 1 | High while a conversion runs |
| sdout | output | 1 | Serial data output |
| rd_error | output | 1 | One-cycle pulse flagging an unfinished read during conversion |

## Verification
On every cycle, the assertions check the following:
- the output stays idle after deselection;
- a busy rise follows a start pulse, and a busy window cannot be cut short by a second start;
- the result is captured when busy falls;
- the error flag appears only as a single pulse at the end of a conversion, and never in read-after-convert mode;
- zeros fill the word once the block's own 16 bits have gone out during a conversion.

Some behaviours involve the host's serial clock and a full scenario, so only the bench scenarios can show them:
- the MSB-first bit order;
- which word is read relative to the conversion in progress;
- chained input bits appearing 16 pulses later;
- a word kept intact across a new start;
- a restart from the MSB after reselection.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
  typedef enum logic {
    RD_AFTER_CONV  = 1'b0,
    RD_DURING_CONV = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rd_sync.sv
`timescale 1ns/1ps
// Multi-bit flop-chain synchronizer for asynchronous host inputs.
module rd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rd_conv_timer.sv
`timescale 1ns/1ps
// Models the conversion as a fixed busy window that ends by capturing a word.
module rd_conv_timer #(
  parameter int DW          = 16,
  parameter int CONV_CYCLES = 400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnv_start,
  input  logic [DW-1:0] result_in,
  output logic          busy,
  output logic          ending,
  output logic [DW-1:0] last_word
);
  localparam int TW = $clog2(CONV_CYCLES + 1);

  logic [TW-1:0] remain;

  assign ending = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      remain    <= '0;
      last_word <= '0;
    end else if (busy) begin
      if (remain == '0) begin
        busy      <= 1'b0;
        last_word <= result_in;
      end else begin
        remain <= remain - 1'b1;
      end
    end else if (cnv_start) begin
      busy   <= 1'b1;
      remain <= TW'(CONV_CYCLES - 1);
    end
  end

  p_rise_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cnv_start));
  p_no_early_end_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && remain != '0) |=> busy);
  p_capture_at_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (last_word == $past(result_in)));
endmodule

// File: rtl/rd_shifter.sv
`timescale 1ns/1ps
// Serial shift engine: selection, bit counting, chain fill and read-error flag.
module rd_shifter
  import adc_rd_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  rd_mode_e      mode,
  input  logic          sclk,
  input  logic          sdin,
  input  logic          busy,
  input  logic          ending,
  input  logic [DW-1:0] last_word,
  output logic          sdout,
  output logic          rd_error
);
  localparam int CW = $clog2(2 * DW) + 1;

  logic          sclk_s, sdin_s, sclk_q;
  logic          fall, rise, sel;
  logic          active, sdin_cap, armed, bits_done;
  logic [DW-1:0] shreg;
  logic [CW-1:0] bcnt;

  rd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, sdin}),
    .q   ({sclk_s, sdin_s})
  );

  assign sel       = ~cs_n & ~rd_n;
  assign fall      = sclk_q & ~sclk_s;
  assign rise      = ~sclk_q & sclk_s;
  assign bits_done = sel && active && fall && (bcnt == CW'(DW - 1));
  assign sdout     = shreg[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      sdin_cap <= 1'b0;
      active   <= 1'b0;
      shreg    <= '0;
      bcnt     <= '0;
      armed    <= 1'b0;
      rd_error <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      rd_error <= 1'b0;
      if (rise) sdin_cap <= sdin_s;

      if (!sel) begin
        active <= 1'b0;
        bcnt   <= '0;
        shreg  <= '0;
      end else if (!active) begin
        active <= 1'b1;
        bcnt   <= '0;
        shreg  <= last_word;
      end else if (fall) begin
        shreg <= {shreg[DW-2:0], (mode == RD_AFTER_CONV) ? sdin_cap : 1'b0};
        if (bcnt != '1) bcnt <= bcnt + 1'b1;
      end

      if (ending) begin
        if (armed && mode == RD_DURING_CONV) rd_error <= 1'b1;
        armed <= 1'b0;
      end else if (bits_done) begin
        armed <= 1'b0;
      end else if (sel && !active && busy) begin
        armed <= 1'b1;
      end
    end
  end

  p_idle_out_r3: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n | rd_n) |-> !sdout);
  p_err_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    rd_error |-> (!busy && $past(busy)));
  p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
    rd_error |=> !rd_error);
  p_err_mode_r6: assert property (@(posedge clk) disable iff (rst)
    $past(mode == RD_AFTER_CONV) |-> !rd_error);
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (active && mode == RD_DURING_CONV && bcnt >= CW'(DW)) |-> !sdout);
endmodule

// File: rtl/adc_serial_readout.sv
`timescale 1ns/1ps
// Top: converter serial result readout in host-clocked mode.
module adc_serial_readout
  import adc_rd_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CONV_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          read_during_conv,
  input  logic          cnv_start,
  input  logic [DW-1:0] result_in,
  input  logic          sclk,
  input  logic          sdin,
  output logic          busy,
  output logic          sdout,
  output logic          rd_error
);
  logic          ending;
  logic [DW-1:0] last_word;

  rd_conv_timer #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .cnv_start (cnv_start),
    .result_in (result_in),
    .busy      (busy),
    .ending    (ending),
    .last_word (last_word)
  );

  rd_shifter #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .mode      (rd_mode_e'(read_during_conv)),
    .sclk      (sclk),
    .sdin      (sdin),
    .busy      (busy),
    .ending    (ending),
    .last_word (last_word),
    .sdout     (sdout),
    .rd_error  (rd_error)
  );
endmodule

// File: tb/test_adc_serial_readout.sv
`timescale 1ns/1ps
module test_adc_serial_readout;
  localparam int DW    = 16;
  localparam int CONV  = 400;
  localparam int HALF  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, mode = 1'b0, cnv_start = 1'b0;
  logic [DW-1:0] result_in = '0;
  logic sclk = 1'b0, sdin = 1'b0;
  logic busy, sdout, rd_error;

  int compared = 0;
  int mismatched = 0;
  int err_pulses = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_serial_readout #(.DW(DW), .CONV_CYCLES(CONV)) i_adc_serial_readout (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
    .read_during_conv(mode), .cnv_start(cnv_start), .result_in(result_in),
    .sclk(sclk), .sdin(sdin), .busy(busy), .sdout(sdout), .rd_error(rd_error)
  );

  // Behavioural reference for the conversion window (R1).
  logic m_busy = 1'b0;
  int   m_left = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0;
      m_left <= 0;
    end else if (m_busy) begin
      if (m_left == 1) m_busy <= 1'b0;
      m_left <= m_left - 1;
    end else if (cnv_start) begin
      m_busy <= 1'b1;
      m_left <= CONV;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      compared++;
      if (busy !== m_busy) begin
        mismatched++;
        $display("FAIL R1 busy: actual %0b expected %0b at %0t", busy, m_busy, $time);
      end
      if (rd_error === 1'b1) err_pulses++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert(input logic [DW-1:0] w);
    result_in = w;
    cnv_start = 1'b1;
    @(negedge clk);
    cnv_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    cycles(2);
  endtask

  task automatic select();
    cs_n = 1'b0;
    rd_n = 1'b0;
    cycles(3);
  endtask

  // Pulses k = kfrom..kto; sdin carries up[16-k] for k <= 16, fill otherwise.
  task automatic pulses(input int kfrom, input int kto, input logic [15:0] up,
                        input logic fill, inout logic [31:0] got);
    for (int k = kfrom; k <= kto; k++) begin
      sdin = (k <= 16) ? up[16-k] : fill;
      cycles(HALF);
      got[32-k] = sdout;
      sclk = 1'b1;
      cycles(HALF);
      sclk = 1'b0;
    end
  endtask

  initial begin
    cycles(150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    cycles(4);
    rst = 1'b0;
    cycles(1);
    // Reset state.
    chk("R3 reset sdout", {31'b0, sdout}, 32'h0);
    chk("R1 reset busy", {31'b0, busy}, 32'h0);
    chk("R6 reset rd_error", {31'b0, rd_error}, 32'h0);

    // Read after conversion with chained word (R2, R4, R8).
    mode = 1'b0;
    convert(16'hA5C3);
    cycles(1);
    chk("R1 busy high after start", {31'b0, busy}, 32'h1);
    wait_idle();
    select();
    got = '0;
    pulses(1, 32, 16'h3C96, 1'b0, got);
    chk("R4 R8 own word then chained word", got, {16'hA5C3, 16'h3C96});
    cs_n = 1'b1;
    cycles(2);
    chk("R3 idle after cs_n high", {31'b0, sdout}, 32'h0);

    // Second start while busy is ignored (R1 via per-cycle compare).
    convert(16'h1234);
    cycles(20);
    convert(16'hEEEE);
    result_in = 16'h1234;
    wait_idle();

    // Read during conversion returns previous result; sdin ignored (R5, R7).
    mode = 1'b1;
    convert(16'hF00F);
    select();
    got = '0;
    pulses(1, 20, 16'hFFFF, 1'b1, got);
    chk("R5 previous result during conversion", got[31:16], 32'h1234);
    chk("R7 sdin ignored, zero fill", {28'b0, got[15:12]}, 32'h0);
    cs_n = 1'b1;
    wait_idle();
    chk("R6 no error after full read", err_pulses, 0);

    // Unfinished read during conversion flags error (R6).
    convert(16'h0FF0);
    select();
    got = '0;
    pulses(1, 5, 16'h0000, 1'b0, got);
    chk("R5 partial read prev word", {27'b0, got[31:27]}, {27'b0, 5'b11110});
    wait_idle();
    chk("R6 single error pulse", err_pulses, 1);
    cs_n = 1'b1;
    cycles(2);

    // Deselect via rd_n restarts from MSB (R10).
    select();
    got = '0;
    pulses(1, 4, 16'h0000, 1'b0, got);
    chk("R10 first bits", {28'b0, got[31:28]}, 32'h0);
    rd_n = 1'b1;
    cycles(2);
    chk("R3 idle after rd_n high", {31'b0, sdout}, 32'h0);
    select();
    got = '0;
    pulses(1, 16, 16'h0000, 1'b0, got);
    chk("R10 restart from MSB", got[31:16], 32'h0FF0);
    cs_n = 1'b1;
    cycles(2);

    // Read crossing a new start keeps the word (R9).
    mode = 1'b0;
    convert(16'h5AA5);
    wait_idle();
    select();
    got = '0;
    pulses(1, 8, 16'hC3C3, 1'b0, got);
    convert(16'h9999);
    pulses(9, 32, 16'hC3C3, 1'b0, got);
    chk("R9 word intact across start", got[31:16], 32'h5AA5);
    chk("R8 chained word after crossing", got[15:0], 32'hC3C3);
    cs_n = 1'b1;
    wait_idle();
    chk("R6 no error in after-convert mode", err_pulses, 1);

    // Latest result after that conversion (R2).
    select();
    got = '0;
    pulses(1, 16, 16'h0000, 1'b0, got);
    chk("R2 latest result captured", got[31:16], 32'h9999);
    cs_n = 1'b1;
    cycles(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule